// File: doc/BRIEF.md
# Video RAM host access controller

This block lets a host processor read and write a 32K-word video memory. The memory is made of two byte-wide arrays, a low lane and a high lane, that share one word address. The host works through strobed byte registers: a configuration byte, the two halves of a word pointer, a byte write port for each lane and a byte read port for each lane. The memory arrays sit outside the block. They are read asynchronously at `mem_addr`.

The configuration byte has three fields. Bit 7 picks which lane's access advances the pointer. Bits 1:0 pick the stride. Bits 3:2 are kept and can be read back, but they do not change the address.

Reads are served from a two-byte prefetch register, not from the memory directly. Loading either pointer byte fetches the addressed word into that register one cycle later. A read on the lane that advances the pointer returns the held byte, then refills the register from the current pointer, then advances the pointer. Reading a block therefore needs one discarded read first.

Memory is only touched while `blank_ok` reports vertical or forced blanking. Outside that window, writes are dropped and every fetch loads all ones.

Top module: `vram_host_ctrl`

## Requirements
- R1: After reset, `mem_addr` is 0, `mode_q` is 0x00, `rd_byte` is 0x00 and neither write enable is high.
- R2: With `blank_ok` high, a low-lane data write raises only `mem_we_lo`, and a high-lane data write raises only `mem_we_hi`. In both cases `mem_wdata` equals `wr_byte` and `mem_addr` is the current pointer.
- R3: With mode bit 7 at 0, low-lane writes and reads advance the pointer and high-lane accesses leave it alone. With bit 7 at 1, the roles of the two lanes are swapped.
- R4: Mode bits 1:0 select the stride: 00 steps by 1, 01 steps by 32, and 10 or 11 steps by 128.
- R5: A low-pointer write loads pointer bits 7:0 from `wr_byte`. A high-pointer write loads pointer bits 14:8 from `wr_byte[6:0]`. `wr_byte[7]` is ignored on a high-pointer write.
- R6: One cycle after a pointer byte write, the prefetch register holds both lanes' bytes at the new pointer.
- R7: A data read returns the prefetched byte of its lane in the same cycle. A read on the advancing lane then reloads both bytes from the pointer before advancing. A read on the other lane changes neither the prefetch register nor the pointer.
- R8: While `blank_ok` is low, no write enable rises, every fetch loads 0xFF into both bytes, and the pointer still advances as set by R3 and R4.
- R9: `mode_q` returns the full configuration byte last written, and bits 3:2 leave the pointer sequence unchanged.
- R10: Pointer arithmetic wraps modulo 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_ok | input | 1 | High during vertical or forced blanking |
| mode_wr | input | 1 | Strobe: load the configuration byte |
| addr_lo_wr | input | 1 | Strobe: load pointer bits 7:0 |
| addr_hi_wr | input | 1 | Strobe: load pointer bits 14:8 |
| data_lo_wr | input | 1 | Strobe: write a byte to the low lane |
| data_hi_wr | input | 1 | Strobe: write a byte to the high lane |
| data_lo_rd | input | 1 | Strobe: read the low prefetched byte |
| data_hi_rd | input | 1 | Strobe: read the high prefetched byte |
| wr_byte | input | 8 | Host write data |
| mem_rdata_lo | input | 8 | Low lane read data at `mem_addr` |
| mem_rdata_hi | input | 8 | High lane read data at `mem_addr` |
| mem_addr | output | 15 | Shared word address to both lanes |
| mem_wdata | output | 8 | Byte to write |
| mem_we_lo | output | 1 | Low lane write enable |
| mem_we_hi | output | 1 | High lane write enable |
| rd_byte | output | 8 | Host read data |
| mode_q | output | 8 | Configuration byte read-back |

## Verification
Some properties are checked on every cycle by the assertions:
- The pointer holds when there is no access, and it moves by exactly the decoded stride when an access advances it.
- The configuration byte holds between writes.
- A fetch made outside blanking fills the prefetch register with ones.
- A pointer write made during blanking loads the memory word one cycle later.

Other behaviour can only be shown by the bench's scenarios:
- The lane selection for each mode value.
- The extra read a block transfer needs, and the repeated byte that appears when it is left out.
- Wrap-around at the top of the address space.
- That the remap bits have no effect.
- That writes are dropped outside blanking while the pointer keeps moving.

// File: rtl/vram_host_pkg.sv
package vram_host_pkg;
  localparam int VRAM_ADDR_W = 15;
  localparam int VRAM_BYTE_W = 8;

  // Stride selected by the two low configuration bits.
  function automatic logic [7:0] step_amount(input logic [1:0] sel);
    logic [7:0] amt;
    unique case (sel)
      2'b00:   amt = 8'd1;
      2'b01:   amt = 8'd32;
      default: amt = 8'd128;
    endcase
    return amt;
  endfunction
endpackage

// File: rtl/vram_mode_reg.sv
module vram_mode_reg #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] mode_q,
  output logic              inc_on_hi,
  output logic [7:0]        step
);
  logic [BYTE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) mode_d = wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign inc_on_hi = mode_q[BYTE_W-1];
  assign step      = vram_host_pkg::step_amount(mode_q[1:0]);

  // R9: configuration byte only changes on its strobe
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/vram_addr_ctr.sv
module vram_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              bump,
  input  logic [7:0]        step,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (lo_wr)      addr_d[BYTE_W-1:0]      = wr_byte;
    else if (hi_wr) addr_d[ADDR_W-1:BYTE_W] = wr_byte[HI_W-1:0];
    else if (bump)  addr_d = addr_q + ADDR_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  // R3: no access that advances, no pointer write -> pointer holds
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bump && !lo_wr && !hi_wr |=> $stable(addr_q));
  // R4 / R10: an advancing access moves by the stride, modulo the space
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bump && !lo_wr && !hi_wr |=> addr_q == ADDR_W'($past(addr_q) + ADDR_W'($past(step))));
endmodule

// File: rtl/vram_prefetch.sv
module vram_prefetch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_set,
  input  logic              fill_now,
  input  logic              blank_ok,
  input  logic [BYTE_W-1:0] mem_rdata_lo,
  input  logic [BYTE_W-1:0] mem_rdata_hi,
  output logic [BYTE_W-1:0] latch_lo,
  output logic [BYTE_W-1:0] latch_hi
);
  logic              pend_q, pend_d;
  logic              pend_ok_q, pend_ok_d;
  logic [BYTE_W-1:0] lo_d, hi_d;
  logic              load_en, load_ok;

  always_comb begin
    pend_d    = addr_set;
    pend_ok_d = blank_ok;
    load_en   = fill_now | pend_q;
    load_ok   = fill_now ? blank_ok : pend_ok_q;
    lo_d      = latch_lo;
    hi_d      = latch_hi;
    if (load_en) begin
      lo_d = load_ok ? mem_rdata_lo : '1;
      hi_d = load_ok ? mem_rdata_hi : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_ok_q <= 1'b0;
      latch_lo  <= '0;
      latch_hi  <= '0;
    end else begin
      pend_q    <= pend_d;
      pend_ok_q <= pend_ok_d;
      latch_lo  <= lo_d;
      latch_hi  <= hi_d;
    end
  end

  // R8: a refill outside blanking yields all ones
  p_dark_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now && !blank_ok |=> (latch_lo == '1) && (latch_hi == '1));
  // R6: pointer write in blanking fetches the new word one cycle later
  p_ptr_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_set && blank_ok) ##1 !fill_now |=>
      (latch_lo == $past(mem_rdata_lo)) && (latch_hi == $past(mem_rdata_hi)));
endmodule

// File: rtl/vram_host_ctrl.sv
module vram_host_ctrl #(
  parameter int ADDR_W = vram_host_pkg::VRAM_ADDR_W,
  parameter int BYTE_W = vram_host_pkg::VRAM_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_ok,
  input  logic              mode_wr,
  input  logic              addr_lo_wr,
  input  logic              addr_hi_wr,
  input  logic              data_lo_wr,
  input  logic              data_hi_wr,
  input  logic              data_lo_rd,
  input  logic              data_hi_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] mem_rdata_lo,
  input  logic [BYTE_W-1:0] mem_rdata_hi,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we_lo,
  output logic              mem_we_hi,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] mode_q
);
  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic              inc_on_hi;
  logic [7:0]        step;
  logic              bump, fill_now;
  logic [BYTE_W-1:0] latch_lo, latch_hi;

  vram_mode_reg #(.BYTE_W(BYTE_W)) u_mode (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .wr_en     (mode_wr),
    .wr_byte   (wr_byte),
    .mode_q    (mode_q),
    .inc_on_hi (inc_on_hi),
    .step      (step)
  );

  always_comb begin
    bump     = inc_on_hi ? (data_hi_wr | data_hi_rd) : (data_lo_wr | data_lo_rd);
    fill_now = inc_on_hi ? data_hi_rd : data_lo_rd;
  end

  vram_addr_ctr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .lo_wr   (addr_lo_wr),
    .hi_wr   (addr_hi_wr),
    .wr_byte (wr_byte),
    .bump    (bump),
    .step    (step),
    .addr_q  (mem_addr)
  );

  vram_prefetch #(.BYTE_W(BYTE_W)) u_pref (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .addr_set     (addr_lo_wr | addr_hi_wr),
    .fill_now     (fill_now),
    .blank_ok     (blank_ok),
    .mem_rdata_lo (mem_rdata_lo),
    .mem_rdata_hi (mem_rdata_hi),
    .latch_lo     (latch_lo),
    .latch_hi     (latch_hi)
  );

  assign mem_wdata = wr_byte;
  assign mem_we_lo = data_lo_wr & blank_ok & core_rst_n;
  assign mem_we_hi = data_hi_wr & blank_ok & core_rst_n;
  assign rd_byte   = data_hi_rd ? latch_hi : latch_lo;
endmodule

// File: tb/vram_host_ctrl_tb.sv
module vram_host_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       blank_ok;
  logic       mode_wr, addr_lo_wr, addr_hi_wr, data_lo_wr, data_hi_wr, data_lo_rd, data_hi_rd;
  logic [7:0] wr_byte;
  logic [7:0] mem_rdata_lo, mem_rdata_hi, mem_wdata, rd_byte, mode_q;
  logic [14:0] mem_addr;
  logic       mem_we_lo, mem_we_hi;

  always #2 clk = ~clk; // 250 MHz

  function automatic logic [7:0] pat_lo(input logic [14:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pat_hi(input logic [14:0] a);
    return {1'b0, a[14:8]} ^ 8'hC3;
  endfunction

  assign mem_rdata_lo = pat_lo(mem_addr);
  assign mem_rdata_hi = pat_hi(mem_addr);

  vram_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .blank_ok(blank_ok),
    .mode_wr(mode_wr), .addr_lo_wr(addr_lo_wr), .addr_hi_wr(addr_hi_wr),
    .data_lo_wr(data_lo_wr), .data_hi_wr(data_hi_wr),
    .data_lo_rd(data_lo_rd), .data_hi_rd(data_hi_rd),
    .wr_byte(wr_byte), .mem_rdata_lo(mem_rdata_lo), .mem_rdata_hi(mem_rdata_hi),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we_lo(mem_we_lo),
    .mem_we_hi(mem_we_hi), .rd_byte(rd_byte), .mode_q(mode_q)
  );

  int vectors = 0;
  int errors  = 0;
  bit mon_on  = 0;

  // Scoreboard queues
  logic [7:0]  rd_q[$];
  string       rd_tag[$];
  logic [23:0] wr_q[$];   // {lane_hi, addr[14:0], data}
  string       wr_tag[$];

  // Reference state
  logic [14:0] exp_addr;
  logic [7:0]  exp_mode, exp_lo, exp_hi;

  function automatic logic [14:0] stride(input logic [7:0] m);
    return (m[1:0] == 2'b00) ? 15'd1 : (m[1:0] == 2'b01) ? 15'd32 : 15'd128;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as the design produces them
  always @(negedge clk) if (mon_on) begin
    if (data_lo_rd || data_hi_rd) begin
      if (rd_q.size() == 0) check("R7 unexpected read", 32'(rd_byte), 32'hDEAD);
      else check(rd_tag.pop_front(), 32'(rd_byte), 32'(rd_q.pop_front()));
    end
    if (mem_we_lo || mem_we_hi) begin
      if (wr_q.size() == 0) check("R8 unexpected write", {mem_we_hi, mem_addr, mem_wdata}, 32'hDEAD);
      else check(wr_tag.pop_front(), {8'h0, mem_we_hi, mem_addr, mem_wdata}, 32'(wr_q.pop_front()));
    end
  end

  // kinds: 0 mode, 1 ptr lo, 2 ptr hi, 3 wr lo, 4 wr hi, 5 rd lo, 6 rd hi
  task automatic op(input int kind, input logic [7:0] v, input string tag);
    bit hi_lane, adv;
    @(posedge clk); #1;
    hi_lane = (kind == 4) || (kind == 6);
    adv     = (kind >= 3) && (hi_lane == exp_mode[7]);
    case (kind)
      0: exp_mode = v;
      1: exp_addr[7:0]  = v;
      2: exp_addr[14:8] = v[6:0];
      3, 4: if (blank_ok) begin
        wr_q.push_back({hi_lane, exp_addr, v});
        wr_tag.push_back(tag);
      end
      default: begin
        rd_q.push_back(hi_lane ? exp_hi : exp_lo);
        rd_tag.push_back(tag);
      end
    endcase
    if (kind == 1 || kind == 2 || (kind >= 5 && adv)) begin
      exp_lo = blank_ok ? pat_lo(exp_addr) : 8'hFF;
      exp_hi = blank_ok ? pat_hi(exp_addr) : 8'hFF;
    end
    if (adv) exp_addr = exp_addr + stride(exp_mode);
    wr_byte = v;
    mode_wr = (kind == 0); addr_lo_wr = (kind == 1); addr_hi_wr = (kind == 2);
    data_lo_wr = (kind == 3); data_hi_wr = (kind == 4);
    data_lo_rd = (kind == 5); data_hi_rd = (kind == 6);
    @(posedge clk); #1;
    {mode_wr, addr_lo_wr, addr_hi_wr, data_lo_wr, data_hi_wr, data_lo_rd, data_hi_rd} = '0;
  endtask

  task automatic chk_ptr(input string req);
    @(negedge clk);
    check(req, 32'(mem_addr), 32'(exp_addr));
  endtask

  task automatic set_ptr(input logic [14:0] a);
    op(1, a[7:0], "R5");
    op(2, {1'b0, a[14:8]}, "R5");
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; blank_ok = 1'b1; wr_byte = '0;
    {mode_wr, addr_lo_wr, addr_hi_wr, data_lo_wr, data_hi_wr, data_lo_rd, data_hi_rd} = '0;
    exp_addr = '0; exp_mode = '0; exp_lo = '0; exp_hi = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr", 32'(mem_addr), 0);
    check("R1 mode", 32'(mode_q), 0);
    check("R1 rd_byte", 32'(rd_byte), 0);
    check("R1 we", {mem_we_lo, mem_we_hi}, 0);
    mon_on = 1;

    // Word mode: advance on high lane, stride 1
    op(0, 8'h80, "R9"); @(negedge clk); check("R9 mode", 32'(mode_q), 32'h80);
    set_ptr(15'h1000); chk_ptr("R5 pointer");
    op(3, 8'h11, "R2 low lane write"); chk_ptr("R3 low access holds in mode 80");
    op(4, 8'h22, "R2 high lane write"); chk_ptr("R3 high access advances");
    // Column mode: stride 32
    op(0, 8'h81, "R9");
    op(3, 8'hAA, "R2"); op(4, 8'hBB, "R2"); chk_ptr("R4 stride 32");
    // Low lane advances
    op(0, 8'h00, "R9");
    op(3, 8'h33, "R2"); chk_ptr("R3 low advances in mode 00");
    op(4, 8'h44, "R2"); chk_ptr("R3 high holds in mode 00");
    op(0, 8'h03, "R9"); op(3, 8'h55, "R2"); chk_ptr("R4 stride 128 sel 11");
    op(0, 8'h02, "R9"); op(3, 8'h66, "R2"); chk_ptr("R4 stride 128 sel 10");
    // Remap bits stored, no effect
    op(0, 8'h8C, "R9"); @(negedge clk); check("R9 readback", 32'(mode_q), 32'h8C);
    op(4, 8'h77, "R2"); chk_ptr("R9 remap bits do not change the pointer");
    // High pointer bit 7 ignored; wrap
    op(2, 8'hFF, "R5"); op(1, 8'hF0, "R5"); chk_ptr("R5 hi bit7 ignored");
    op(0, 8'h02, "R9"); op(3, 8'h88, "R2"); chk_ptr("R10 wrap");

    // Prefetch reads, high lane advances
    op(0, 8'h80, "R9"); set_ptr(15'h1234);
    op(5, 0, "R6 fetched low byte");
    op(6, 0, "R6 fetched high byte");
    op(6, 0, "R7 repeated byte without dummy read");
    op(5, 0, "R7 low read returns refilled byte");
    op(6, 0, "R7 next word");
    chk_ptr("R7 pointer after reads");
    // Low lane advances, stride 32
    op(0, 8'h01, "R9"); set_ptr(15'h0456);
    op(5, 0, "R7 dummy"); op(5, 0, "R7 block low 0"); op(5, 0, "R7 block low 1");
    op(6, 0, "R7 high non-advancing"); chk_ptr("R7 pointer low mode");

    // Outside blanking
    blank_ok = 1'b0;
    op(0, 8'h00, "R9");
    op(3, 8'h99, "R8 dropped write"); chk_ptr("R8 pointer still advances");
    op(5, 0, "R8 returns held byte"); op(5, 0, "R8 ones after dark fill");
    op(6, 0, "R8 high ones");
    set_ptr(15'h0100);
    blank_ok = 1'b1;
    op(6, 0, "R8 dark pointer fetch gives ones");
    op(5, 0, "R8 low ones then refill");
    op(5, 0, "R7 valid after blank returns");
    chk_ptr("R8 pointer");

    repeat (3) @(posedge clk);
    check("R7 reads all consumed", rd_q.size(), 0);
    check("R2 writes all consumed", wr_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule